// File: doc/BRIEF.md
# Motion Delta Accumulator

This block collects signed per-frame displacement increments for two axes and turns them into what a host sees when it polls for motion: one signed 8-bit count per axis plus a motion status byte. The tracking engine presents a valid strobe with one X and one Y increment per frame. The serial-port front end presents read and write strobes with a 7-bit register address. No write data enters the block, because a written byte is never stored.

Reporting depends on the order of the reads. The host reads the X count first. That read clears the X accumulator and takes a snapshot of the Y accumulator at the same moment. The next Y read returns the snapshot, so the X and Y values the host receives describe the same span of time. Motion that arrives between the two reads builds up in a fresh Y accumulation and is reported on the next pass.

The motion flag records that nonzero motion has occurred and has not yet been fully reported. A write to the status address discards all pending motion. Both accumulators saturate at the ends of the signed 8-bit range instead of wrapping.

Top module: `motion_delta_acc`

## Requirements
- R1: After reset, `status_o`, `dx_o` and `dy_o` are all 0x00.
- R2: `dx_o` and `dy_o` show the value that the next read of the X register (address 0x03) or the Y register (address 0x04) returns. Each is the two's complement sum of the increments since that axis was last reported.
- R3: Accumulation saturates: a sum above +127 gives 0x7F and a sum below -128 gives 0x80.
- R4: A read strobe at address 0x03 clears the X accumulator from the next cycle.
- R5: A read at 0x03 captures the current Y accumulation into a holding register and restarts Y accumulation from zero. Until a read at 0x04 consumes the holding register, `dy_o` shows the captured value. After that read, `dy_o` shows the Y motion accumulated since the X read.
- R6: A read at 0x04 with no capture pending returns the Y accumulator, clears it, and leaves the motion flag unchanged.
- R7: The status byte (address 0x02) carries the motion flag in bit 7, and bits 6:0 are always 0. A read at 0x02 changes nothing.
- R8: An increment with a nonzero dx or dy sets the motion flag. A valid increment with both values zero does not set it.
- R9: A read at 0x04 that consumes a capture clears the motion flag, unless a nonzero increment has arrived since the X read. In that case the flag stays set.
- R10: A write strobe at 0x02 clears both accumulators, the holding register and the motion flag.
- R11: When a read or a clearing write lands in the same cycle as an increment, that increment becomes the new accumulator value. A nonzero increment in that cycle also sets the flag.
- R12: Read strobes at any address other than 0x03 or 0x04, and write strobes at any address other than 0x02, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | Per-frame increment valid |
| frm_dx | input | 8 | Signed X increment |
| frm_dy | input | 8 | Signed Y increment |
| rd_stb | input | 1 | Register read strobe |
| wr_stb | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address for the strobe |
| status_o | output | 8 | Status byte, motion flag in bit 7 |
| dx_o | output | 8 | X count that the next X read returns |
| dy_o | output | 8 | Y count that the next Y read returns |

## Verification
The hardest state to reach is a pending Y capture with fresh Y motion arriving behind it. In that state `dy_o` must keep showing the snapshot while a separate accumulation grows, and the flag outcome of the following Y read depends on that late motion. The bench gets there with an X read, then a Y-only increment, then a Y read. It repeats the X and Y reads with no motion in between to show the flag dropping. Same-cycle collisions of a read or a clearing write with an increment are driven directly to cover the cases where the increment is kept.

// File: rtl/mda_pkg.sv
package mda_pkg;
    localparam int DELTA_W = 8;
    localparam int ADDR_W  = 7;

    typedef logic signed [DELTA_W-1:0] delta_t;
    typedef logic [ADDR_W-1:0]         addr_t;

    localparam delta_t DELTA_MAX = delta_t'((2 ** (DELTA_W - 1)) - 1);
    localparam delta_t DELTA_MIN = delta_t'(-(2 ** (DELTA_W - 1)));

    localparam addr_t ADDR_STATUS = addr_t'(7'h02);
    localparam addr_t ADDR_XCNT   = addr_t'(7'h03);
    localparam addr_t ADDR_YCNT   = addr_t'(7'h04);

    typedef struct packed {
        logic rd_x;
        logic rd_y;
        logic clr;
    } host_op_t;

    function automatic delta_t sat_add(input delta_t a, input delta_t b);
        logic signed [DELTA_W:0] s;
        s = {a[DELTA_W-1], a} + {b[DELTA_W-1], b};
        if (s > $signed({1'b0, DELTA_MAX}))
            return DELTA_MAX;
        else if (s < $signed({1'b1, DELTA_MIN}))
            return DELTA_MIN;
        else
            return s[DELTA_W-1:0];
    endfunction
endpackage

// File: rtl/mda_decode.sv
module mda_decode
    import mda_pkg::*;
(
    input  logic     rd_stb,
    input  logic     wr_stb,
    input  addr_t    reg_addr,
    output host_op_t op
);
    always_comb begin
        op.rd_x = rd_stb && (reg_addr == ADDR_XCNT);
        op.rd_y = rd_stb && (reg_addr == ADDR_YCNT);
        op.clr  = wr_stb && (reg_addr == ADDR_STATUS);
    end
endmodule

// File: rtl/mda_axis.sv
module mda_axis
    import mda_pkg::*;
#(
    parameter bit HOLD = 1'b0
)(
    input  logic   clk,
    input  logic   rst,
    input  logic   inc_vld,
    input  delta_t inc,
    input  logic   clr_all,
    input  logic   take,
    input  logic   snap,
    output delta_t rpt,
    output logic   hold_vld
);
    delta_t acc_q, base, acc_n;
    logic   snap_eff, take_live, zero_base;

    assign take_live = take && !hold_vld;
    assign zero_base = clr_all || take_live || snap_eff;

    always_comb begin
        base  = zero_base ? '0 : acc_q;
        acc_n = inc_vld ? sat_add(base, inc) : base;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_n;
    end

    generate
        if (HOLD) begin : g_hold
            delta_t hold_q;
            logic   hv_q;
            assign snap_eff = snap;
            assign hold_vld = hv_q;
            assign rpt      = hv_q ? hold_q : acc_q;

            always_ff @(posedge clk) begin
                if (rst || clr_all) begin
                    hold_q <= '0;
                    hv_q   <= 1'b0;
                end else if (snap) begin
                    hold_q <= acc_q;
                    hv_q   <= 1'b1;
                end else if (take && hv_q) begin
                    hv_q   <= 1'b0;
                end
            end

            // R5
            snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
                snap && !clr_all |=> hv_q && (hold_q == $past(acc_q)));
        end else begin : g_direct
            assign snap_eff = snap & 1'b0;
            assign hold_vld = 1'b0;
            assign rpt      = acc_q;
        end
    endgenerate

    // R10
    clr_wipes_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all && !inc_vld |=> acc_q == '0);
    // R4
    take_clears_chk: assert property (@(posedge clk) disable iff (rst)
        take && !hold_vld && !inc_vld |=> acc_q == '0);
    // R11
    read_keeps_inc_chk: assert property (@(posedge clk) disable iff (rst)
        take && !hold_vld && inc_vld && !clr_all |=> acc_q == $past(inc));
    // R3
    sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        inc_vld && !zero_base && (acc_q == DELTA_MAX) && !inc[DELTA_W-1] |=> acc_q == DELTA_MAX);
    // R3
    sat_low_chk: assert property (@(posedge clk) disable iff (rst)
        inc_vld && !zero_base && (acc_q == DELTA_MIN) && inc[DELTA_W-1] |=> acc_q == DELTA_MIN);
endmodule

// File: rtl/mda_flag.sv
module mda_flag
    import mda_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   inc_vld,
    input  delta_t inc_x,
    input  delta_t inc_y,
    input  logic   clr_all,
    input  logic   rd_x,
    input  logic   y_done,
    output logic   flag
);
    logic nz, fresh_q;

    assign nz = inc_vld && ((inc_x != '0) || (inc_y != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            fresh_q <= 1'b0;
        end else begin
            if (clr_all || rd_x) fresh_q <= nz;
            else if (nz)         fresh_q <= 1'b1;

            if (clr_all)     flag <= nz;
            else if (nz)     flag <= 1'b1;
            else if (y_done) flag <= fresh_q;
        end
    end

    // R8
    motion_sets_chk: assert property (@(posedge clk) disable iff (rst)
        nz |=> flag);
    // R10
    write_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all && !nz |=> !flag);
    // R7
    idle_holds_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_all && !rd_x && !y_done && !nz |=> flag == $past(flag));
endmodule

// File: rtl/motion_delta_acc.sv
module motion_delta_acc
    import mda_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frm_vld,
    input  logic [7:0] frm_dx,
    input  logic [7:0] frm_dy,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic [6:0] reg_addr,
    output logic [7:0] status_o,
    output logic [7:0] dx_o,
    output logic [7:0] dy_o
);
    host_op_t op;
    delta_t   rpt_x, rpt_y;
    logic     x_hold_unused, y_hold_vld, flag;

    mda_decode u_dec (
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .reg_addr(reg_addr),
        .op      (op)
    );

    mda_axis #(.HOLD(1'b0)) u_ax_x (
        .clk     (clk),
        .rst     (rst),
        .inc_vld (frm_vld),
        .inc     (delta_t'(frm_dx)),
        .clr_all (op.clr),
        .take    (op.rd_x),
        .snap    (1'b0),
        .rpt     (rpt_x),
        .hold_vld(x_hold_unused)
    );

    mda_axis #(.HOLD(1'b1)) u_ax_y (
        .clk     (clk),
        .rst     (rst),
        .inc_vld (frm_vld),
        .inc     (delta_t'(frm_dy)),
        .clr_all (op.clr),
        .take    (op.rd_y),
        .snap    (op.rd_x),
        .rpt     (rpt_y),
        .hold_vld(y_hold_vld)
    );

    mda_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .inc_vld(frm_vld),
        .inc_x  (delta_t'(frm_dx)),
        .inc_y  (delta_t'(frm_dy)),
        .clr_all(op.clr),
        .rd_x   (op.rd_x),
        .y_done (op.rd_y && y_hold_vld && !x_hold_unused),
        .flag   (flag)
    );

    assign status_o = {flag, 7'b0};
    assign dx_o     = rpt_x;
    assign dy_o     = rpt_y;
endmodule

// File: tb/motion_delta_acc_tb.sv
module motion_delta_acc_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frm_vld = 1'b0;
    logic [7:0] frm_dx = '0, frm_dy = '0;
    logic       rd_stb = 1'b0, wr_stb = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [7:0] status_o, dx_o, dy_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    motion_delta_acc dut_i (
        .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_dx(frm_dx), .frm_dy(frm_dy),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_addr(reg_addr),
        .status_o(status_o), .dx_o(dx_o), .dy_o(dy_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: driven on a falling edge, released on the next falling edge
    task automatic cyc(input logic v, input logic [7:0] dx, input logic [7:0] dy,
                       input logic rd, input logic wr, input logic [6:0] a);
        @(negedge clk);
        frm_vld = v; frm_dx = dx; frm_dy = dy;
        rd_stb = rd; wr_stb = wr; reg_addr = a;
        @(negedge clk);
        frm_vld = 0; frm_dx = 0; frm_dy = 0; rd_stb = 0; wr_stb = 0; reg_addr = 0;
    endtask

    task automatic inc(input logic [7:0] dx, input logic [7:0] dy);
        cyc(1, dx, dy, 0, 0, 7'h00);
    endtask
    task automatic rd(input logic [6:0] a);
        cyc(0, 0, 0, 1, 0, a);
    endtask
    task automatic wipe();
        cyc(0, 0, 0, 0, 1, 7'h02);
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 8'h00);
        chk("R1 dx", dx_o, 8'h00);
        chk("R1 dy", dy_o, 8'h00);
    endtask

    task automatic t_accumulate();
        wipe();
        inc(8'h00, 8'h00);
        chk("R8 zero increment leaves flag", status_o, 8'h00);
        inc(8'd3, 8'hFE);
        inc(8'd5, 8'hFC);
        chk("R2 dx sum", dx_o, 8'd8);
        chk("R2 dy sum", dy_o, 8'hFA);
        chk("R8 flag set", status_o, 8'h80);
    endtask

    task automatic t_saturate();
        wipe();
        inc(8'd100, 8'h9C);
        inc(8'd100, 8'h9C);
        chk("R3 positive clamp", dx_o, 8'h7F);
        chk("R3 negative clamp", dy_o, 8'h80);
    endtask

    task automatic t_read_order();
        wipe();
        inc(8'd4, 8'd6);
        rd(7'h03);
        chk("R4 X cleared", dx_o, 8'h00);
        chk("R5 snapshot shown", dy_o, 8'd6);
        inc(8'h00, 8'd2);
        chk("R5 snapshot kept", dy_o, 8'd6);
        rd(7'h04);
        chk("R5 later motion shown", dy_o, 8'd2);
        chk("R9 flag kept by late motion", status_o, 8'h80);
        rd(7'h03);
        rd(7'h04);
        chk("R5 empty after second pass", dy_o, 8'h00);
        chk("R9 flag cleared", status_o, 8'h00);
    endtask

    task automatic t_y_alone();
        wipe();
        inc(8'h00, 8'hF9);
        chk("R6 Y before read", dy_o, 8'hF9);
        rd(7'h04);
        chk("R6 Y cleared", dy_o, 8'h00);
        chk("R6 flag unchanged", status_o, 8'h80);
    endtask

    task automatic t_status_read();
        wipe();
        inc(8'd9, 8'd1);
        rd(7'h02);
        chk("R7 status value", status_o, 8'h80);
        chk("R7 dx untouched", dx_o, 8'd9);
        chk("R7 dy untouched", dy_o, 8'd1);
    endtask

    task automatic t_write_clear();
        inc(8'd7, 8'd7);
        rd(7'h03);
        wipe();
        chk("R10 dx", dx_o, 8'h00);
        chk("R10 dy incl. snapshot", dy_o, 8'h00);
        chk("R10 flag", status_o, 8'h00);
    endtask

    task automatic t_collide();
        wipe();
        inc(8'd5, 8'd0);
        cyc(1, 8'd2, 8'd0, 1, 0, 7'h03);
        chk("R11 read keeps increment", dx_o, 8'd2);
        cyc(1, 8'd3, 8'd0, 0, 1, 7'h02);
        chk("R11 write keeps increment", dx_o, 8'd3);
        chk("R11 flag from colliding increment", status_o, 8'h80);
    endtask

    task automatic t_ignored();
        wipe();
        inc(8'd11, 8'd12);
        rd(7'h05);
        cyc(0, 0, 0, 0, 1, 7'h03);
        cyc(0, 0, 0, 0, 1, 7'h04);
        cyc(0, 0, 0, 1, 0, 7'h42);
        chk("R12 dx", dx_o, 8'd11);
        chk("R12 dy", dy_o, 8'd12);
        chk("R12 flag", status_o, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_accumulate();
        t_saturate();
        t_read_order();
        t_y_alone();
        t_status_read();
        t_write_clear();
        t_collide();
        t_ignored();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule